// File: doc/BRIEF.md
# Microprocessor Bus Trace Capture Unit

This block watches the bus of an 8-bit microprocessor without driving it. Each bus cycle is recognised from the processor's phase-2 clock. The unit first samples the address and the R/W, SYNC and IRQ lines. Later in the high half of the cycle it samples the data lines twice, a few ticks apart. It packs the result into one 32-bit trace word. All bus inputs pass through two-flop synchronisers into a faster local sampling clock. Both sample points are programmable delays, counted in local ticks from the detected phase-2 rising edge.

After a start command the unit hunts for a programmable trigger address. The cycle that carries this address becomes word 0 of the buffer. Every later cycle is stored in order until the buffer is full. Capture also ends early if the two data samples of a cycle disagree, which shows that the data was not stable. An abort input stops a capture at any moment, so a trigger that never comes does not need a reset. Stored words and the final count are read through a synchronous read port.

Top module: `bus_trace_capture`

## Requirements
- R1: After reset the unit is idle: `busy`, `done`, `fail`, `trig_hit` and `cap_strobe` are low and `count` is 0.
- R2: A `start` pulse clears `done`, `fail`, `trig_hit` and `count`, and in the next cycle `busy` is high and the unit is hunting for the trigger.
- R3: While hunting, cycles whose sampled address differs from `trig_addr` are not stored. The first cycle whose address equals `trig_addr` raises `trig_hit` and is stored at buffer index 0.
- R4: After the trigger, every bus cycle is stored at the next buffer index and `count` rises by exactly one per stored cycle.
- R5: A trace word holds the address in bits 15:0, the data in 23:16, R/W in bit 24, SYNC in bit 25 and IRQ in bit 26. Bits 31:27 are zero.
- R6: Address and control lines are taken `addr_dly` ticks after the phase-2 rise is detected. Data is taken at `data_dly` ticks and again at `data_dly`+GAP ticks. Bus values present only outside these points do not reach the stored word.
- R7: If the two data samples of a cycle differ, `fail` and `done` go high, the unit goes idle, and that cycle is not stored (`count` unchanged).
- R8: When `count` reaches DEPTH, `done` goes high, the unit goes idle, and further bus cycles change nothing.
- R9: `cap_strobe` is high from the tick after the phase-2 rise is detected until that cycle is finished. This lasts `data_dly`+GAP+1 ticks for a cycle that is stored or fails, and `addr_dly`+1 ticks for a cycle rejected while hunting. It is low while idle and between cycles.
- R10: `abort` sends the unit to idle in the next cycle, whether it is hunting or recording. Later bus cycles leave `count` and `trig_hit` unchanged.
- R11: `rd_data` shows the word stored at `rd_addr` one clock after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| phi2 | input | 1 | Processor phase-2 clock (asynchronous) |
| bus_addr | input | 16 | Processor address bus |
| bus_data | input | 8 | Processor data bus |
| bus_rw | input | 1 | Read/write line |
| bus_sync | input | 1 | Opcode-fetch indicator |
| bus_irq | input | 1 | Interrupt request line |
| start | input | 1 | Clear status and begin hunting for the trigger |
| abort | input | 1 | Return to idle; has priority over start |
| trig_addr | input | 16 | Trigger address |
| addr_dly | input | DLY_W | Ticks from phase-2 rise to address/control sample |
| data_dly | input | DLY_W | Ticks from phase-2 rise to first data sample |
| rd_addr | input | log2(DEPTH) | Buffer read index |
| rd_data | output | 32 | Stored trace word, one-cycle latency |
| busy | output | 1 | Hunting or recording |
| done | output | 1 | Capture ended (buffer full or data mismatch) |
| fail | output | 1 | Data samples disagreed |
| trig_hit | output | 1 | Trigger address found, recording active |
| cap_strobe | output | 1 | High while a bus cycle is being sampled and stored |
| count | output | log2(DEPTH+1) | Number of stored words |

## Verification
The assertions rely on a few conditions at the inputs. `data_dly` is larger than `addr_dly`. `data_dly`+GAP ticks end before the phase-2 clock falls. The phase-2 low time covers the synchroniser delay, so no rising edge arrives while a cycle is still being sampled. The bench uses a fixed 10-tick low and 20-tick high phase-2 clock with delays of 3 and 8 ticks and a gap of 4. It changes the address only before the rise and then scrambles it well after the address sample. It presents data well before the first data sample and holds it past the second, except in the cycle built to cause a mismatch. Random addresses, data and control bits come from a seeded generator. Directed cases cover a trigger at address 0, a trigger on the first cycle, a full buffer, a mismatch, and an abort both while hunting and while recording.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN
  } seq_state_t;

  typedef struct packed {
    logic irq;
    logic sync;
    logic rw;
  } bus_ctl_t;

  // Trace word: [15:0] address, [23:16] data, [24] rw, [25] sync, [26] irq.
  function automatic logic [31:0] pack_trace(logic [15:0] a, logic [7:0] d, bus_ctl_t c);
    return {5'b0, c.irq, c.sync, c.rw, d, a};
  endfunction

endpackage

// File: rtl/trace_sync.sv
module trace_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/trace_buf.sv
module trace_buf #(
  parameter int DEPTH = 1024,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_word,
  input  logic [AW-1:0] rd_idx,
  output logic [W-1:0]  rd_word
);

  logic [W-1:0] store [DEPTH];
  logic [W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store[wr_idx] <= wr_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= store[rd_idx];
    end
  end

  assign rd_word = rd_q;

endmodule

// File: rtl/trace_seq.sv
module trace_seq
  import trace_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DLY_W = 6,
  parameter int GAP   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int TW   = DLY_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phi2_s,
  input  logic [15:0]      addr_s,
  input  logic [7:0]       data_s,
  input  bus_ctl_t         ctl_s,
  input  logic             start,
  input  logic             abort,
  input  logic [15:0]      trig_addr,
  input  logic [DLY_W-1:0] addr_dly,
  input  logic [DLY_W-1:0] data_dly,
  output logic             wr_en,
  output logic [AW-1:0]    wr_idx,
  output logic [31:0]      wr_word,
  output logic [CW-1:0]    count,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             trig_hit,
  output logic             cap_strobe
);

  seq_state_t    state_q, state_n;
  logic          phi2_q;
  logic [TW-1:0] tick_q, tick_n;
  logic [15:0]   addr_q, addr_n;
  bus_ctl_t      ctl_q, ctl_n;
  logic [7:0]    d0_q, d0_n;
  logic [CW-1:0] count_q, count_n;
  logic          done_q, done_n;
  logic          fail_q, fail_n;
  logic          hit_q, hit_n;
  logic          rise;
  logic          at_addr, at_d0, at_d1;

  assign rise    = phi2_s & ~phi2_q;
  assign at_addr = (tick_q == TW'(addr_dly));
  assign at_d0   = (tick_q == TW'(data_dly));
  assign at_d1   = (tick_q == TW'(data_dly) + TW'(GAP));

  // Next-state logic
  always_comb begin
    state_n = state_q;
    tick_n  = tick_q;
    addr_n  = addr_q;
    ctl_n   = ctl_q;
    d0_n    = d0_q;
    count_n = count_q;
    done_n  = done_q;
    fail_n  = fail_q;
    hit_n   = hit_q;
    wr_en   = 1'b0;
    if (abort) begin
      state_n = ST_IDLE;
    end else if (start) begin
      state_n = ST_WAIT;
      count_n = '0;
      done_n  = 1'b0;
      fail_n  = 1'b0;
      hit_n   = 1'b0;
    end else begin
      unique case (state_q)
        ST_WAIT: begin
          if (rise) begin
            state_n = ST_RUN;
            tick_n  = '0;
          end
        end
        ST_RUN: begin
          tick_n = tick_q + TW'(1);
          if (at_addr) begin
            addr_n = addr_s;
            ctl_n  = ctl_s;
            if (!hit_q) begin
              if (addr_s == trig_addr) begin
                hit_n = 1'b1;
              end else begin
                state_n = ST_WAIT;
              end
            end
          end
          if (at_d0) begin
            d0_n = data_s;
          end
          if (at_d1) begin
            if (data_s != d0_q) begin
              fail_n  = 1'b1;
              done_n  = 1'b1;
              state_n = ST_IDLE;
            end else begin
              wr_en   = 1'b1;
              count_n = count_q + CW'(1);
              if (count_q == CW'(DEPTH - 1)) begin
                done_n  = 1'b1;
                state_n = ST_IDLE;
              end else begin
                state_n = ST_WAIT;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phi2_q  <= 1'b0;
      tick_q  <= '0;
      addr_q  <= '0;
      ctl_q   <= '0;
      d0_q    <= '0;
      count_q <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      phi2_q  <= phi2_s;
      tick_q  <= tick_n;
      addr_q  <= addr_n;
      ctl_q   <= ctl_n;
      d0_q    <= d0_n;
      count_q <= count_n;
      done_q  <= done_n;
      fail_q  <= fail_n;
      hit_q   <= hit_n;
    end
  end

  assign wr_idx     = count_q[AW-1:0];
  assign wr_word    = pack_trace(addr_q, data_s, ctl_q);
  assign count      = count_q;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign fail       = fail_q;
  assign trig_hit   = hit_q;
  assign cap_strobe = (state_q == ST_RUN);

endmodule

// File: rtl/bus_trace_capture.sv
module bus_trace_capture
  import trace_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DLY_W = 6,
  parameter int GAP   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int BW   = 1 + 3 + 8 + 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phi2,
  input  logic [15:0]      bus_addr,
  input  logic [7:0]       bus_data,
  input  logic             bus_rw,
  input  logic             bus_sync,
  input  logic             bus_irq,
  input  logic             start,
  input  logic             abort,
  input  logic [15:0]      trig_addr,
  input  logic [DLY_W-1:0] addr_dly,
  input  logic [DLY_W-1:0] data_dly,
  input  logic [AW-1:0]    rd_addr,
  output logic [31:0]      rd_data,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             trig_hit,
  output logic             cap_strobe,
  output logic [CW-1:0]    count
);

  logic [BW-1:0] raw_bus;
  logic [BW-1:0] syn_bus;
  logic          phi2_s;
  logic [15:0]   addr_s;
  logic [7:0]    data_s;
  bus_ctl_t      ctl_s;
  logic          wr_en;
  logic [AW-1:0] wr_idx;
  logic [31:0]   wr_word;

  assign raw_bus = {phi2, bus_irq, bus_sync, bus_rw, bus_data, bus_addr};

  trace_sync #(.W(BW)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_bus),
    .q     (syn_bus)
  );

  assign {phi2_s, ctl_s, data_s, addr_s} = syn_bus;

  trace_seq #(.DEPTH(DEPTH), .DLY_W(DLY_W), .GAP(GAP)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .phi2_s     (phi2_s),
    .addr_s     (addr_s),
    .data_s     (data_s),
    .ctl_s      (ctl_s),
    .start      (start),
    .abort      (abort),
    .trig_addr  (trig_addr),
    .addr_dly   (addr_dly),
    .data_dly   (data_dly),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_word    (wr_word),
    .count      (count),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .trig_hit   (trig_hit),
    .cap_strobe (cap_strobe)
  );

  trace_buf #(.DEPTH(DEPTH), .W(32)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_word (wr_word),
    .rd_idx  (rd_addr),
    .rd_word (rd_data)
  );

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
  parameter int DEPTH = 1024,
  parameter int CW    = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          abort,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          trig_hit,
  input logic          cap_strobe,
  input logic [CW-1:0] count
);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> (count == '0 && !done && !fail && !trig_hit && busy));

  a_r3_nothing_before_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_hit |-> (count == '0));

  a_r4_count_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (count == $past(count) || count == $past(count) + CW'(1)));

  a_r7_fail_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (done && !busy));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r8_done_freezes_count: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(count));

  a_r9_strobe_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cap_strobe);

  a_r10_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

endmodule

bind bus_trace_capture trace_capture_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/tb_bus_trace_capture.sv
module tb_bus_trace_capture;

  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int CW    = 5;
  localparam int DW    = 6;
  localparam int ADLY  = 3;
  localparam int DDLY  = 8;
  localparam int GAP   = 4;

  logic          clk;
  logic          rst_n;
  logic          phi2;
  logic [15:0]   bus_addr;
  logic [7:0]    bus_data;
  logic          bus_rw, bus_sync, bus_irq;
  logic          start, abort;
  logic [15:0]   trig_addr;
  logic [DW-1:0] addr_dly, data_dly;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;
  logic          busy, done, fail, trig_hit, cap_strobe;
  logic [CW-1:0] count;

  int n_chk, n_bad;
  bit finished;

  logic [31:0] exp_mem [DEPTH];
  int  exp_cnt;
  bit  exp_busy, exp_hunt, exp_done, exp_fail, exp_hit;

  bus_trace_capture #(.DEPTH(DEPTH), .DLY_W(DW), .GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rw(bus_rw), .bus_sync(bus_sync), .bus_irq(bus_irq), .start(start), .abort(abort),
    .trig_addr(trig_addr), .addr_dly(addr_dly), .data_dly(data_dly), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done), .fail(fail), .trig_hit(trig_hit),
    .cap_strobe(cap_strobe), .count(count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic [15:0] a, input logic [7:0] d,
                                       input logic r, input logic s, input logic i);
    return {5'b0, i, s, r, d, a};
  endfunction

  // One bus cycle: 10 ticks phase-2 low, 20 ticks high.
  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic r,
                           input logic s, input logic i, input bit glitch);
    int hi_cnt;
    int exp_hi;
    hi_cnt = 0;
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      if (cap_strobe) hi_cnt++;
      case (j)
        0: begin
          phi2 = 1'b0; bus_addr = a; bus_rw = r; bus_sync = s; bus_irq = i;
          bus_data = d ^ 8'hA5;
        end
        10: phi2 = 1'b1;
        15: bus_data = d;
        19: begin bus_addr = ~a; bus_rw = ~r; bus_sync = ~s; bus_irq = ~i; end
        21: if (glitch) bus_data = ~d;
        default: ;
      endcase
    end
    exp_hi = 0;
    if (exp_busy) begin
      if (exp_hunt && a != trig_addr) begin
        exp_hi = ADLY + 1;
      end else begin
        exp_hunt = 1'b0;
        exp_hit  = 1'b1;
        exp_hi   = DDLY + GAP + 1;
        if (glitch) begin
          exp_fail = 1'b1; exp_done = 1'b1; exp_busy = 1'b0;
        end else begin
          exp_mem[exp_cnt] = pack(a, d, r, s, i);
          exp_cnt++;
          if (exp_cnt == DEPTH) begin
            exp_done = 1'b1; exp_busy = 1'b0;
          end
        end
      end
    end
    chk("R9 strobe ticks per cycle", hi_cnt, exp_hi);
  endtask

  task automatic rand_cycle(input bit avoid_trig);
    logic [15:0] a;
    a = 16'($urandom);
    if (avoid_trig && a == trig_addr) a = a ^ 16'h0001;
    bus_cycle(a, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    exp_busy = 1'b1; exp_hunt = 1'b1; exp_cnt = 0;
    exp_done = 1'b0; exp_fail = 1'b0; exp_hit = 1'b0;
  endtask

  task automatic do_abort();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    exp_busy = 1'b0;
  endtask

  task automatic check_status(input string req);
    @(negedge clk);
    chk({req, " count"}, 32'(count), 32'(exp_cnt));
    chk({req, " busy"}, 32'(busy), 32'(exp_busy));
    chk({req, " done"}, 32'(done), 32'(exp_done));
    chk({req, " fail"}, 32'(fail), 32'(exp_fail));
    chk({req, " trig_hit"}, 32'(trig_hit), 32'(exp_hit));
  endtask

  task automatic readback();
    for (int k = 0; k < exp_cnt; k++) begin
      @(negedge clk); rd_addr = AW'(k);
      @(negedge clk);
      chk("R5 R6 R11 stored word", rd_data, exp_mem[k]);
    end
  endtask

  initial begin
    int seed_set;
    seed_set = $urandom(32'd13579);
    n_chk = 0; n_bad = 0; finished = 1'b0;
    rst_n = 1'b0; phi2 = 1'b0; bus_addr = '0; bus_data = '0;
    bus_rw = 1'b0; bus_sync = 1'b0; bus_irq = 1'b0;
    start = 1'b0; abort = 1'b0; trig_addr = '0;
    addr_dly = DW'(ADLY); data_dly = DW'(DDLY); rd_addr = '0;
    exp_busy = 0; exp_hunt = 0; exp_done = 0; exp_fail = 0; exp_hit = 0; exp_cnt = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset strobe", 32'(cap_strobe), 32'd0);
    check_status("R1 reset");
    rst_n = 1'b1;

    // Idle: bus activity without start stores nothing
    rand_cycle(1'b0);
    check_status("R1 idle ignores bus");

    // Hunt then record
    trig_addr = 16'h1234;
    do_start();
    check_status("R2 after start");
    for (int n = 0; n < 5; n++) rand_cycle(1'b1);
    check_status("R3 no store before trigger");
    bus_cycle(16'h1234, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0);
    check_status("R3 trigger found");
    for (int n = 0; n < 6; n++) rand_cycle(1'b0);
    check_status("R4 cycles after trigger");
    readback();

    // Abort while recording
    do_abort();
    rand_cycle(1'b0);
    rand_cycle(1'b0);
    check_status("R10 abort while recording");

    // Trigger on first cycle, fill the buffer
    trig_addr = 16'hFFFC;
    do_start();
    check_status("R2 restart clears");
    bus_cycle(16'hFFFC, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int n = 0; n < DEPTH + 2; n++) rand_cycle(1'b0);
    check_status("R8 buffer full");
    readback();

    // Trigger at address zero, then a data mismatch
    trig_addr = 16'h0000;
    do_start();
    rand_cycle(1'b1);
    bus_cycle(16'h0000, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b0);
    rand_cycle(1'b0);
    rand_cycle(1'b0);
    bus_cycle(16'h4242, 8'h81, 1'b1, 1'b0, 1'b0, 1'b1);
    check_status("R7 data mismatch");
    rand_cycle(1'b0);
    check_status("R7 idle after mismatch");
    readback();

    // Trigger never arrives, abort while hunting
    trig_addr = 16'hBEEF;
    do_start();
    for (int n = 0; n < 3; n++) rand_cycle(1'b1);
    do_abort();
    rand_cycle(1'b0);
    check_status("R10 abort while hunting");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule